// File: doc/BRIEF.md
# Flash Write-Status Output Generator

This block models, cycle by cycle, the status logic a parallel NOR flash shows on its read bus while an internal program or erase is running. A one-cycle start pulse, given at the end of the command sequence, launches an operation. The pulse carries the operation kind, the byte being programmed, and a flag saying whether the target is protected. While the operation runs, each read strobe returns a status byte instead of array contents. Bit 7 is a polling bit, bit 6 is a toggle bit and bit 5 is a time-limit flag. When the block is idle, reads return the array byte supplied from outside.

Program and erase durations are parameters counted in clock cycles. The short dummy busy windows for a protected program target and for an erase whose selected sectors are all protected are also parameters in cycles. At the end of an unprotected operation the block gives a one-cycle commit pulse, which tells the array to apply the change. A protected operation ends without that pulse, so the array is left as it was. Whether only part of an erase selection is protected is decided outside the block: that case arrives as an unprotected erase.

Top module: `flash_status_gen`

## Requirements
- R1: After reset `busy_o`, `commit_o` and `rd_data_o` are all zero.
- R2: A start pulse while idle makes `busy_o` high for exactly PROG_CYCLES cycles (program, `op_erase_i`=0) or ERASE_CYCLES cycles (erase, `op_erase_i`=1). After an unprotected operation, `commit_o` is high for the single cycle in which `busy_o` has first returned low.
- R3: During a program operation, a read with `addr_hit_i`=1 returns bit 7 as the inverse of bit 7 of the latched program byte.
- R4: During an erase operation, a read with `addr_hit_i`=1 returns bit 7 as 0.
- R5: A busy read with `addr_hit_i`=0 returns bit 7 equal to `array_data_i[7]`. A busy read returns bits 4..0 as zero at any address.
- R6: Bit 6 of a busy read inverts on every busy read strobe, at any address. The toggle state does not change while the block is idle, so the first busy read of the next operation continues the sequence.
- R7: Bit 5 of a busy read is 1 when the number of completed busy cycles before the strobe is at least TIMEOUT_CYCLES, and 0 otherwise.
- R8: A protected program (`target_prot_i`=1, `op_erase_i`=0) stays busy for PROT_PROG_CYCLES cycles and gives no commit pulse.
- R9: A protected erase (`target_prot_i`=1, `op_erase_i`=1) stays busy for PROT_ERASE_CYCLES cycles and gives no commit pulse.
- R10: An idle read returns `array_data_i` on `rd_data_o` one cycle after the strobe. `rd_data_o` holds its value in cycles without a strobe.
- R11: A start pulse while busy is ignored. The duration, the polled bit and the operation kind of the running operation stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse at the end of the command sequence |
| op_erase_i | input | 1 | Operation kind: 0 program, 1 erase |
| prog_data_i | input | 8 | Byte being programmed |
| target_prot_i | input | 1 | Program target protected, or every erase sector protected |
| rd_i | input | 1 | Read strobe |
| addr_hit_i | input | 1 | Read address is the program address or lies in an erase sector |
| array_data_i | input | 8 | Array contents at the read address |
| rd_data_o | output | 8 | Registered read data or status byte |
| busy_o | output | 1 | Internal operation in progress |
| commit_o | output | 1 | One-cycle pulse: apply the finished operation to the array |

## Verification
Two events fall in the same cycle when a read strobe is issued in the last busy cycle of an operation. The bench provokes this by reading in every busy cycle of every operation. It requires that the strobe in the final busy cycle still returns a status byte, with the polling bit, the next toggle value and the time-limit flag, even though `busy_o` drops and `commit_o` rises at that same edge. A second collision comes from a start pulse raised together with a read during an operation. The bench judges it by the unchanged duration and the unchanged polling bit that follow.

// File: rtl/flash_status_pkg.sv
// Package: shared constants and helpers for the flash write-status generator.
// Assumes an 8-bit read bus with status bits at fixed positions.
package flash_status_pkg;

    localparam int DATA_W   = 8;
    localparam int POLL_POS = 7;
    localparam int TOG_POS  = 6;
    localparam int TMO_POS  = 5;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    // Larger of two non-negative integers, for sizing counters.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsg_op_timer.sv
// Module: operation timer. Latches an operation on a start pulse while
// idle, counts its duration, reports elapsed-cycle timeout and issues a
// commit pulse on completion of an unprotected operation.
// Assumes every duration parameter is at least 1.
module fsg_op_timer
    import flash_status_pkg::*;
#(
    parameter int PROG_CYCLES       = 8,
    parameter int ERASE_CYCLES      = 20,
    parameter int PROT_PROG_CYCLES  = 4,
    parameter int PROT_ERASE_CYCLES = 12,
    parameter int TIMEOUT_CYCLES    = 15
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  op_kind_e op_i,
    input  logic     data_msb_i,
    input  logic     prot_i,
    output logic     busy_o,
    output logic     poll_o,
    output logic     timeout_o,
    output logic     commit_o
);

    localparam int MAXC = max2(max2(max2(PROG_CYCLES, ERASE_CYCLES),
                                    max2(PROT_PROG_CYCLES, PROT_ERASE_CYCLES)),
                               TIMEOUT_CYCLES);
    localparam int CW = $clog2(MAXC + 2);

    localparam logic [CW-1:0] LAST_PROG   = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] LAST_ERASE  = CW'(ERASE_CYCLES - 1);
    localparam logic [CW-1:0] LAST_PPROG  = CW'(PROT_PROG_CYCLES - 1);
    localparam logic [CW-1:0] LAST_PERASE = CW'(PROT_ERASE_CYCLES - 1);
    localparam logic [CW-1:0] TMO_LIM     = CW'(TIMEOUT_CYCLES);

    logic          busy_q;
    logic          poll_q;
    logic          prot_q;
    logic          commit_q;
    logic [CW-1:0] remain_q;
    logic [CW-1:0] elapsed_q;
    logic [CW-1:0] load_val;

    // Choose the countdown load value from the operation kind and protection.
    always_comb begin
        unique case ({prot_i, op_i})
            {1'b0, OP_PROGRAM}: load_val = LAST_PROG;
            {1'b0, OP_ERASE}:   load_val = LAST_ERASE;
            {1'b1, OP_PROGRAM}: load_val = LAST_PPROG;
            default:            load_val = LAST_PERASE;
        endcase
    end

    // Sequence idle -> busy -> idle, counting duration and elapsed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            poll_q    <= 1'b0;
            prot_q    <= 1'b0;
            commit_q  <= 1'b0;
            remain_q  <= '0;
            elapsed_q <= '0;
        end else begin
            commit_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q    <= 1'b1;
                    remain_q  <= load_val;
                    elapsed_q <= '0;
                    prot_q    <= prot_i;
                    poll_q    <= (op_i == OP_ERASE) ? 1'b0 : ~data_msb_i;
                end
            end else begin
                if (remain_q == '0) begin
                    busy_q   <= 1'b0;
                    commit_q <= ~prot_q;
                end else begin
                    remain_q <= remain_q - 1'b1;
                end
                if (elapsed_q != '1) begin
                    elapsed_q <= elapsed_q + 1'b1;
                end
            end
        end
    end

    assign busy_o    = busy_q;
    assign poll_o    = poll_q;
    assign commit_o  = commit_q;
    assign timeout_o = busy_q && (elapsed_q >= TMO_LIM);

    // R11
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_i && remain_q != '0) |=> (busy_q && $stable(poll_q) && $stable(prot_q)));

    // R2
    commit_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> (!busy_q && $past(busy_q)));

    // R8
    prot_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && prot_q) |=> !commit_q);

endmodule

// File: rtl/fsg_toggle.sv
// Module: toggle-bit state. Flips on every read strobe while an operation
// is busy and holds its value while idle.
// Assumes read strobes are single-cycle qualified by rd_i.
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic rd_i,
    output logic tog_o
);

    logic tog_q;

    // Invert the toggle state on each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= 1'b0;
        end else if (busy_i && rd_i) begin
            tog_q <= ~tog_q;
        end
    end

    assign tog_o = tog_q;

    // R6
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_i) |=> (tog_q != $past(tog_q)));

    // R6
    toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> $stable(tog_q));

endmodule

// File: rtl/fsg_read_mux.sv
// Module: read-data register. On a strobe it captures either array data
// (idle) or the status byte (busy); otherwise it holds its last value.
// Assumes status bit positions from the package.
module fsg_read_mux
    import flash_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              busy_i,
    input  logic              hit_i,
    input  logic              poll_i,
    input  logic              tog_i,
    input  logic              tmo_i,
    input  logic [DATA_W-1:0] array_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] status_byte;
    logic [DATA_W-1:0] data_q;

    // Assemble the status byte presented during a busy read.
    always_comb begin
        status_byte           = '0;
        status_byte[POLL_POS] = hit_i ? poll_i : array_i[POLL_POS];
        status_byte[TOG_POS]  = tog_i;
        status_byte[TMO_POS]  = tmo_i;
    end

    // Capture read data on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_i) begin
            data_q <= busy_i ? status_byte : array_i;
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/flash_status_gen.sv
// Module: top of the flash write-status generator. Ties together the
// operation timer, toggle state and read-data register.
// Assumes start_i is a single-cycle pulse at the end of a command sequence.
module flash_status_gen
    import flash_status_pkg::*;
#(
    parameter int PROG_CYCLES       = 1750,
    parameter int ERASE_CYCLES      = 250000,
    parameter int PROT_PROG_CYCLES  = 500,
    parameter int PROT_ERASE_CYCLES = 25000,
    parameter int TIMEOUT_CYCLES    = 200000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       op_erase_i,
    input  logic [7:0] prog_data_i,
    input  logic       target_prot_i,
    input  logic       rd_i,
    input  logic       addr_hit_i,
    input  logic [7:0] array_data_i,
    output logic [7:0] rd_data_o,
    output logic       busy_o,
    output logic       commit_o
);

    logic     busy;
    logic     poll;
    logic     tmo;
    logic     tog;
    op_kind_e op_kind;

    assign op_kind = op_kind_e'(op_erase_i);

    fsg_op_timer #(
        .PROG_CYCLES      (PROG_CYCLES),
        .ERASE_CYCLES     (ERASE_CYCLES),
        .PROT_PROG_CYCLES (PROT_PROG_CYCLES),
        .PROT_ERASE_CYCLES(PROT_ERASE_CYCLES),
        .TIMEOUT_CYCLES   (TIMEOUT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_kind),
        .data_msb_i(prog_data_i[POLL_POS]),
        .prot_i    (target_prot_i),
        .busy_o    (busy),
        .poll_o    (poll),
        .timeout_o (tmo),
        .commit_o  (commit_o)
    );

    fsg_toggle u_toggle (
        .clk   (clk),
        .rst_n (rst_n),
        .busy_i(busy),
        .rd_i  (rd_i),
        .tog_o (tog)
    );

    fsg_read_mux u_rdmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_i   (rd_i),
        .busy_i (busy),
        .hit_i  (addr_hit_i),
        .poll_i (poll),
        .tog_i  (tog),
        .tmo_i  (tmo),
        .array_i(array_data_i),
        .data_o (rd_data_o)
    );

    assign busy_o = busy;

    // R10
    idle_read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !busy_o) |=> (rd_data_o == $past(array_data_i)));

    // R10
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rd_data_o));

    // R5
    busy_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && busy_o) |=> (rd_data_o[4:0] == 5'b0));

endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;

    localparam int P_PROG  = 8;
    localparam int P_ERASE = 20;
    localparam int P_PPROG = 4;
    localparam int P_PERAS = 12;
    localparam int P_TMO   = 15;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic       op_erase_i;
    logic [7:0] prog_data_i;
    logic       target_prot_i;
    logic       rd_i;
    logic       addr_hit_i;
    logic [7:0] array_data_i;
    logic [7:0] rd_data_o;
    logic       busy_o;
    logic       commit_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic exp_tog = 1'b0;

    always #2 clk = ~clk;

    flash_status_gen #(
        .PROG_CYCLES      (P_PROG),
        .ERASE_CYCLES     (P_ERASE),
        .PROT_PROG_CYCLES (P_PPROG),
        .PROT_ERASE_CYCLES(P_PERAS),
        .TIMEOUT_CYCLES   (P_TMO)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .op_erase_i   (op_erase_i),
        .prog_data_i  (prog_data_i),
        .target_prot_i(target_prot_i),
        .rd_i         (rd_i),
        .addr_hit_i   (addr_hit_i),
        .array_data_i (array_data_i),
        .rd_data_o    (rd_data_o),
        .busy_o       (busy_o),
        .commit_o     (commit_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0; start_i = 0; op_erase_i = 0; prog_data_i = 0;
        target_prot_i = 0; rd_i = 0; addr_hit_i = 0; array_data_i = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", busy_o, 0);
        check("R1 commit", commit_o, 0);
        check("R1 rd_data", rd_data_o, 0);
    endtask

    // R10: idle read passes array data, then holds
    task automatic t_idle_read(input logic [7:0] val);
        array_data_i = val; rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        check("R10 idle read", rd_data_o, val);
        array_data_i = ~val;
        @(negedge clk);
        check("R10 hold", rd_data_o, val);
    endtask

    // R2..R9, R11: run one operation, reading in every busy cycle
    task automatic t_op(input logic erase, input logic [7:0] data, input logic prot,
                        input logic hit, input int exp_dur, input int kick);
        int nbusy = 0;
        logic pend = 1'b0;
        logic [7:0] exp_b = 8'h00;
        array_data_i = 8'hA5;
        op_erase_i = erase; prog_data_i = data; target_prot_i = prot;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (nbusy < 1000) begin
            if (pend) check(hit ? (erase ? "R4 R6 R7 busy byte" : "R3 R6 R7 busy byte")
                                : "R5 R6 R7 busy byte", rd_data_o, exp_b);
            pend = 1'b0;
            if (!busy_o) break;
            nbusy++;
            rd_i = 1'b1; addr_hit_i = hit;
            exp_b = 8'h00;
            exp_b[7] = hit ? (erase ? 1'b0 : ~data[7]) : array_data_i[7];
            exp_b[6] = exp_tog;
            exp_b[5] = ((nbusy - 1) >= P_TMO);
            exp_tog = ~exp_tog;
            pend = 1'b1;
            if (nbusy == kick) begin
                start_i = 1'b1; op_erase_i = ~erase; prog_data_i = ~data; target_prot_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        rd_i = 1'b0; start_i = 1'b0;
        check(prot ? (erase ? "R9 duration" : "R8 duration")
                   : (kick > 0 ? "R11 duration" : "R2 duration"), nbusy, exp_dur);
        check(prot ? "R8 R9 no commit" : "R2 commit", commit_o, !prot);
        @(negedge clk);
        check("R2 commit single", commit_o, 0);
    endtask

    initial begin
        #400000;
        n_fails++; n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_idle_read(8'h3C);
        t_op(1'b0, 8'h80, 1'b0, 1'b1, P_PROG, -1);   // R3 R2
        t_op(1'b0, 8'h12, 1'b0, 1'b1, P_PROG, -1);   // R3 with bit7 clear
        t_idle_read(8'hC3);                          // R6 toggle held while idle
        t_op(1'b1, 8'hFF, 1'b0, 1'b1, P_ERASE, -1);  // R4 R7
        t_op(1'b0, 8'h00, 1'b0, 1'b0, P_PROG, -1);   // R5
        t_op(1'b0, 8'h7F, 1'b1, 1'b1, P_PPROG, -1);  // R8
        t_op(1'b1, 8'h00, 1'b1, 1'b1, P_PERAS, -1);  // R9
        t_op(1'b0, 8'h00, 1'b0, 1'b1, P_PROG, 3);    // R11
        t_idle_read(8'h5A);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule